// File: doc/BRIEF.md
# Page-Mode Controller for Address-Multiplexed Asynchronous DRAM

This block sits between a synchronous client and an asynchronous DRAM of 256K words by 8 bits whose row and column addresses share nine address pins. The client presents one word request at a time, either a read or a write, and holds it until the controller acknowledges it. The controller opens the addressed row with the row strobe, then performs the column access with the column strobe. It keeps the row open afterwards, so that later requests to the same row cost only a column cycle.

Every analog timing minimum of the memory is a nanosecond parameter. It is turned into a whole number of clock cycles, rounded up, from a clock-period parameter. A refresh scheduler asks for one row-strobe-only cycle per row interval, stepping through all rows within the retention window. A pending refresh closes an open page in preference to further client traffic. With the default 10 ns clock the derived counts are: row access 6, row cycle 11, column access 2, page cycle 4, row precharge 5, row-to-column delay 4, refresh interval 1562 cycles.

Top module: `dram_pagectl`

## Requirements
- R1: While reset is held, both strobes, write enable and output enable are high (inactive), the data drivers are off, and neither req_ack nor rsp_valid is asserted.
- R2: The 18-bit word address splits with the row in bits 17..9 and the column in bits 8..0. The row is on the address pins when the row strobe falls, and the column is on them when the column strobe falls.
- R3: Two falling edges of the row strobe are at least 11 cycles apart, and the row strobe stays high at least 5 cycles before it falls again.
- R4: The column strobe is low only while the row strobe is low. It falls at least 4 cycles after the row strobe falls, and the row strobe stays low at least 6 cycles before it rises.
- R5: A request to the row that is already open is served with no new row-strobe cycle, and consecutive falling edges of the column strobe are at least 4 cycles apart.
- R6: A write is an early write. Write enable is low and the data drivers carry the request's data in the cycle before the column strobe falls and at that fall. The column strobe stays low at least 2 cycles.
- R7: A read is an early read. Output enable is low before the column strobe falls, and the data is captured 2 cycles after that fall. rsp_valid pulses exactly 2 cycles after req_ack with the stored word. Write enable and output enable are never low together.
- R8: A request to a row other than the open one raises the row strobe and opens the new row, with exactly one new row-strobe cycle.
- R9: Refresh cycles lower only the row strobe and present rows 0, 1, 2, ... in order, wrapping at 512. They follow one another every 1562 cycles, within a service slack, and no refresh request is lost.
- R10: A pending refresh closes an open page and is served before any further client column access. A stream of same-row requests cannot delay refresh beyond the slack.
- R11: req_ack is a one-cycle pulse issued on the edge where the column strobe falls for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client request present, held until req_ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address, row in bits 17..9, column in 8..0 |
| req_wdata | input | 8 | Write data |
| req_ack | output | 1 | Request taken, one-cycle pulse |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | 8 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 9 | Multiplexed row/column address pins |
| dram_dq_out | output | 8 | Data driven to the memory |
| dram_dq_oe | output | 1 | 1 = controller drives the data pins |
| dram_dq_in | input | 8 | Data returned by the memory |

## Verification
A stale open-row register shows up at the next request. The acknowledge then arrives with the wrong number of row-strobe cycles before it, or with a row on the pins that differs from the request, and both appear within about twelve cycles. A counter that releases a strobe early breaks a minimum spacing at the very edge concerned. A read captured too early returns the memory model's inverted junk word, and this shows on rsp_rdata two cycles after the acknowledge. A refresh scheduler that drops or starves a request shows up as a refresh gap beyond the interval and slack, or as a row out of sequence, no later than the next refresh slot.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  localparam int CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROWSET,
    ST_REFRESH,
    ST_COLSET,
    ST_CASLOW,
    ST_PAGE
  } seq_state_t;

  // whole clock cycles covering a time in ns, rounded up
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  // true on the edge that completes 'need' cycles after an event,
  // given 'since' = edges counted after the event edge
  function automatic logic elapsed_ok(input cnt_t since, input cnt_t need);
    return ({1'b0, since} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, need};
  endfunction

endpackage

// File: rtl/dpc_elapsed.sv
module dpc_elapsed
  import dpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  output cnt_t since
);
  // saturating count of edges since the last event; saturated after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             since <= '1;
    else if (evt)           since <= '0;
    else if (since != '1)   since <= since + cnt_t'(1);
  end
endmodule

// File: rtl/dpc_refresh_sched.sv
module dpc_refresh_sched #(
  parameter int unsigned INTERVAL = 1562,
  parameter int unsigned ROW_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  output logic             pend,
  output logic             tick,
  output logic [ROW_W-1:0] row
);
  localparam int unsigned TW = $clog2(INTERVAL + 1);
  logic [TW-1:0] tmr;

  assign tick = (tmr == TW'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr  <= '0;
      pend <= 1'b0;
      row  <= '0;
    end else begin
      tmr <= tick ? '0 : tmr + TW'(1);
      if (tick)      pend <= 1'b1;
      else if (done) pend <= 1'b0;
      if (done)      row  <= row + ROW_W'(1);
    end
  end
endmodule

// File: rtl/dram_pagectl.sv
module dram_pagectl
  import dpc_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS     = 10,
  parameter int unsigned T_RAC_NS          = 60,
  parameter int unsigned T_RC_NS           = 110,
  parameter int unsigned T_CAC_NS          = 15,
  parameter int unsigned T_PC_NS           = 35,
  parameter int unsigned T_RP_NS           = 50,
  parameter int unsigned REFRESH_WINDOW_NS = 8_000_000,
  parameter int unsigned ROW_W             = 9,
  parameter int unsigned COL_W             = 9,
  parameter int unsigned DATA_W            = 8,
  localparam int unsigned AW               = ROW_W + COL_W,
  localparam int unsigned PIN_W            = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [PIN_W-1:0]  dram_addr,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  localparam cnt_t RAC_C = cnt_t'(ns_to_cyc(T_RAC_NS, CLK_PERIOD_NS));
  localparam cnt_t RC_C  = cnt_t'(ns_to_cyc(T_RC_NS,  CLK_PERIOD_NS));
  localparam cnt_t CAC_C = cnt_t'(ns_to_cyc(T_CAC_NS, CLK_PERIOD_NS));
  localparam cnt_t PC_C  = cnt_t'(ns_to_cyc(T_PC_NS,  CLK_PERIOD_NS));
  localparam cnt_t RP_C  = cnt_t'(ns_to_cyc(T_RP_NS,  CLK_PERIOD_NS));
  localparam cnt_t RCD_C = (RAC_C > CAC_C) ? cnt_t'(RAC_C - CAC_C) : cnt_t'(1);
  localparam int unsigned ROWS    = 1 << ROW_W;
  localparam int unsigned REF_INT = REFRESH_WINDOW_NS / ROWS / CLK_PERIOD_NS;

  seq_state_t state;
  logic              ras_n_q, cas_n_q, we_n_q, oe_n_q, dq_oe_q;
  logic [DATA_W-1:0] dq_out_q, rsp_d_q;
  logic [PIN_W-1:0]  addr_q;
  logic [ROW_W-1:0]  open_row;
  logic              is_ref, setup_q, cur_wr, ack_q, rsp_v_q;

  // named internal events, also watched by the checker
  cnt_t since_rf, since_rr, since_cf;
  logic ras_fall_evt, ras_rise_evt, cas_fall_evt, cas_rise_evt;
  logic ref_pend, ref_tick, ref_done, refresh_active;
  logic [ROW_W-1:0] ref_row;
  logic row_timing_ok, col_timing_ok, cas_done, ras_min_ok;
  logic page_hit, page_close;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;

  assign req_row = req_addr[AW-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];

  assign row_timing_ok = elapsed_ok(since_rr, RP_C) && elapsed_ok(since_rf, RC_C);
  assign col_timing_ok = setup_q && elapsed_ok(since_rf, RCD_C) && elapsed_ok(since_cf, PC_C);
  assign cas_done      = elapsed_ok(since_cf, CAC_C);
  assign ras_min_ok    = elapsed_ok(since_rf, RAC_C);
  assign page_hit      = req_valid && (req_row == open_row);
  assign page_close    = ref_pend || (req_valid && !page_hit);

  assign ras_fall_evt  = (state == ST_ROWSET) && row_timing_ok;
  assign cas_fall_evt  = (state == ST_COLSET) && col_timing_ok;
  assign cas_rise_evt  = (state == ST_CASLOW) && cas_done;
  assign ref_done      = (state == ST_REFRESH) && ras_min_ok;
  assign ras_rise_evt  = ref_done || ((state == ST_PAGE) && page_close && ras_min_ok);
  assign refresh_active = (state == ST_REFRESH);

  dpc_elapsed u_rf (.clk(clk), .rst_n(rst_n), .evt(ras_fall_evt), .since(since_rf));
  dpc_elapsed u_rr (.clk(clk), .rst_n(rst_n), .evt(ras_rise_evt), .since(since_rr));
  dpc_elapsed u_cf (.clk(clk), .rst_n(rst_n), .evt(cas_fall_evt), .since(since_cf));

  dpc_refresh_sched #(.INTERVAL(REF_INT), .ROW_W(ROW_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .done(ref_done),
    .pend(ref_pend), .tick(ref_tick), .row(ref_row)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ras_n_q  <= 1'b1;
      cas_n_q  <= 1'b1;
      we_n_q   <= 1'b1;
      oe_n_q   <= 1'b1;
      dq_oe_q  <= 1'b0;
      dq_out_q <= '0;
      addr_q   <= '0;
      open_row <= '0;
      is_ref   <= 1'b0;
      setup_q  <= 1'b0;
      cur_wr   <= 1'b0;
      ack_q    <= 1'b0;
      rsp_v_q  <= 1'b0;
      rsp_d_q  <= '0;
    end else begin
      ack_q   <= 1'b0;
      rsp_v_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ref_pend) begin
            addr_q <= PIN_W'(ref_row);
            is_ref <= 1'b1;
            state  <= ST_ROWSET;
          end else if (req_valid) begin
            addr_q   <= PIN_W'(req_row);
            open_row <= req_row;
            is_ref   <= 1'b0;
            state    <= ST_ROWSET;
          end
        end
        ST_ROWSET: begin
          if (ras_fall_evt) begin
            ras_n_q <= 1'b0;
            setup_q <= 1'b0;
            state   <= is_ref ? ST_REFRESH : ST_COLSET;
          end
        end
        ST_REFRESH: begin
          if (ref_done) begin
            ras_n_q <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        ST_COLSET: begin
          addr_q   <= PIN_W'(req_col);
          we_n_q   <= ~req_write;
          oe_n_q   <= req_write;
          dq_oe_q  <= req_write;
          dq_out_q <= req_wdata;
          setup_q  <= 1'b1;
          if (cas_fall_evt) begin
            cas_n_q <= 1'b0;
            ack_q   <= 1'b1;
            cur_wr  <= req_write;
            state   <= ST_CASLOW;
          end
        end
        ST_CASLOW: begin
          if (cas_rise_evt) begin
            cas_n_q <= 1'b1;
            we_n_q  <= 1'b1;
            oe_n_q  <= 1'b1;
            dq_oe_q <= 1'b0;
            if (!cur_wr) begin
              rsp_v_q <= 1'b1;
              rsp_d_q <= dram_dq_in;
            end
            state <= ST_PAGE;
          end
        end
        ST_PAGE: begin
          if (page_close) begin
            if (ras_min_ok) begin
              ras_n_q <= 1'b1;
              state   <= ST_IDLE;
            end
          end else if (req_valid) begin
            setup_q <= 1'b0;
            state   <= ST_COLSET;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dram_ras_n  = ras_n_q;
  assign dram_cas_n  = cas_n_q;
  assign dram_we_n   = we_n_q;
  assign dram_oe_n   = oe_n_q;
  assign dram_addr   = addr_q;
  assign dram_dq_out = dq_out_q;
  assign dram_dq_oe  = dq_oe_q;
  assign req_ack     = ack_q;
  assign rsp_valid   = rsp_v_q;
  assign rsp_rdata   = rsp_d_q;
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int RC_CYC = 11,
  parameter int PC_CYC = 4,
  parameter int PIN_W  = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             oe_n,
  input logic             dq_oe,
  input logic [PIN_W-1:0] addr,
  input logic             ack,
  input logic             ref_tick,
  input logic             ref_pend,
  input logic             refresh_active
);
  logic        ras_q, cas_q;
  logic [15:0] rf_gap, cf_gap;
  logic        ras_fall_seen, cas_fall_seen;

  assign ras_fall_seen = ras_q && !ras_n;
  assign cas_fall_seen = cas_q && !cas_n;

  // gap counters measured from the strobe pins only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      rf_gap <= '1;
      cf_gap <= '1;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      if (ras_fall_seen)       rf_gap <= 16'd1;
      else if (rf_gap != '1)   rf_gap <= rf_gap + 16'd1;
      if (cas_fall_seen)       cf_gap <= 16'd1;
      else if (cf_gap != '1)   cf_gap <= cf_gap + 16'd1;
    end
  end

  p_row_addr_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(addr));

  p_row_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ras_fall_seen |-> (int'(rf_gap) >= RC_CYC));

  p_cas_inside_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  p_page_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cas_fall_seen |-> (int'(cf_gap) >= PC_CYC));

  p_early_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !we_n) |-> ($past(we_n) == 1'b0 && dq_oe));

  p_we_oe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n || oe_n));

  p_refresh_ras_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_active |-> cas_n);

  p_no_lost_refresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |-> !ref_pend);

  p_ack_with_cas_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $fell(cas_n));

  p_ack_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
endmodule

bind dram_pagectl dpc_checker #(
  .RC_CYC(int'(RC_C)),
  .PC_CYC(int'(PC_C)),
  .PIN_W(int'(PIN_W))
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .ras_n(dram_ras_n),
  .cas_n(dram_cas_n),
  .we_n(dram_we_n),
  .oe_n(dram_oe_n),
  .dq_oe(dram_dq_oe),
  .addr(dram_addr),
  .ack(req_ack),
  .ref_tick(ref_tick),
  .ref_pend(ref_pend),
  .refresh_active(refresh_active)
);

// File: tb/dram_pagectl_tb_top.sv
module dram_pagectl_tb_top;
  // cycle counts restated from the requirements for a 10 ns clock
  localparam int RAC = 6, RC = 11, CAC = 2, PC = 4, RP = 5, RCD = 4;
  localparam int REF_INT = 1562, SLACK = 60, WDOG = 150000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       c_valid, c_write;
  logic [17:0] c_addr;
  logic [7:0] c_wdata;
  logic       req_ack, rsp_valid;
  logic [7:0] rsp_rdata;
  logic       ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [8:0] pins;
  logic [7:0] dq_out;
  logic [7:0] dq_in = 8'h5A;

  dram_pagectl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(c_valid), .req_write(c_write), .req_addr(c_addr), .req_wdata(c_wdata),
    .req_ack(req_ack), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_addr(pins), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
  );

  int tests = 0, fails = 0, n = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", rq, act, exp, n);
    end
  endtask

  function automatic logic [7:0] dflt(input int a);
    return 8'(a) ^ 8'(a >> 9);
  endfunction

  // memory device model and reference state
  logic [7:0] dev_mem[int];
  logic [7:0] exp_mem[int];
  int  q_data[$];
  int  q_n[$];
  int  ras_fall_n = -1000, ras_rise_n = -1000, cas_fall_n = -1000, last_cas_in_row = -1000;
  int  ras_falls = 0, refreshes = 0, exp_ref_row = 0, last_ref_n = 0;
  int  prev_row = -1, falls_at_ack = 0, refs_at_ack = 0;
  bit  cas_seen_in_row = 0, p_ras = 1, p_cas = 1, p_we = 1, p_oe = 1, p_ack = 0;
  logic [8:0] lat_row = '0, lat_col = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      n++;
      // row strobe falling
      if (p_ras && !ras_n) begin
        chk(n - ras_fall_n >= RC, "R3 row cycle", n - ras_fall_n, RC);
        chk(n - ras_rise_n >= RP, "R3 row precharge", n - ras_rise_n, RP);
        ras_fall_n = n; ras_falls++; lat_row = pins; cas_seen_in_row = 0;
      end
      // column strobe falling
      if (p_cas && !cas_n) begin
        chk(!ras_n, "R4 column inside row", ras_n, 0);
        chk(n - ras_fall_n >= RCD, "R4 row to column", n - ras_fall_n, RCD);
        if (cas_seen_in_row) chk(n - last_cas_in_row >= PC, "R5 page cycle", n - last_cas_in_row, PC);
        cas_seen_in_row = 1; last_cas_in_row = n; cas_fall_n = n; lat_col = pins;
        chk(we_n || oe_n, "R7 we/oe exclusive", {we_n, oe_n}, 3);
        if (!we_n) begin
          chk(!p_we && dq_oe, "R6 early write", {p_we, dq_oe}, 1);
          dev_mem[int'({lat_row, lat_col})] = dq_out;
        end else begin
          chk(!p_oe && !oe_n, "R7 early read", {p_oe, oe_n}, 0);
        end
      end
      // acknowledge
      if (req_ack) begin
        int row, fs, rs, ef, a;
        a   = int'(c_addr);
        row = int'(c_addr[17:9]);
        chk(!p_ack, "R11 ack single pulse", p_ack, 0);
        chk(p_cas && !cas_n, "R11 ack at column fall", cas_n, 0);
        chk(lat_row == c_addr[17:9], "R2 row pins", lat_row, row);
        chk(lat_col == c_addr[8:0], "R2 column pins", lat_col, int'(c_addr[8:0]));
        fs = ras_falls - falls_at_ack; rs = refreshes - refs_at_ack;
        if (prev_row >= 0) begin
          ef = (prev_row == row && rs == 0) ? 0 : rs + 1;
          if (prev_row == row) chk(fs == ef, "R5 page hit row cycles", fs, ef);
          else                 chk(fs == ef, "R8 row miss row cycles", fs, ef);
        end
        prev_row = row; falls_at_ack = ras_falls; refs_at_ack = refreshes;
        if (c_write) begin
          chk(dq_out == c_wdata, "R6 write data", dq_out, c_wdata);
          exp_mem[a] = c_wdata;
        end else begin
          q_data.push_back(exp_mem.exists(a) ? int'(exp_mem[a]) : int'(dflt(a)));
          q_n.push_back(n);
        end
      end
      // read response
      if (rsp_valid) begin
        if (q_data.size() == 0) chk(0, "R7 unexpected response", 1, 0);
        else begin
          int ed, en;
          ed = q_data.pop_front(); en = q_n.pop_front();
          chk(int'(rsp_rdata) == ed, "R7 read data", rsp_rdata, ed);
          chk(n - en == CAC, "R7 response latency", n - en, CAC);
        end
      end
      // column strobe rising
      if (!p_cas && cas_n) chk(n - cas_fall_n >= CAC, "R6 column low time", n - cas_fall_n, CAC);
      // row strobe rising
      if (!p_ras && ras_n) begin
        chk(cas_n, "R4 column high at row close", cas_n, 1);
        chk(n - ras_fall_n >= RAC, "R4 row low time", n - ras_fall_n, RAC);
        ras_rise_n = n;
        if (!cas_seen_in_row) begin
          chk(int'(lat_row) == exp_ref_row, "R9 refresh row order", lat_row, exp_ref_row);
          chk(n - last_ref_n <= REF_INT + SLACK, "R10 refresh not starved", n - last_ref_n, REF_INT + SLACK);
          chk(n - last_ref_n >= REF_INT - SLACK, "R9 refresh spacing", n - last_ref_n, REF_INT - SLACK);
          exp_ref_row = (exp_ref_row + 1) % 512; last_ref_n = n; refreshes++;
        end
      end
      // memory drives read data, junk until both access times have passed
      if (!ras_n && !cas_n && !oe_n) begin
        int a; logic [7:0] d;
        a = int'({lat_row, lat_col});
        d = dev_mem.exists(a) ? dev_mem[a] : dflt(a);
        dq_in <= ((n - cas_fall_n + 1 >= CAC) && (n - ras_fall_n + 1 >= RAC)) ? d : ~d;
      end else dq_in <= 8'h5A;
      p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_oe = oe_n; p_ack = req_ack;
      if (n >= WDOG) begin
        chk(0, "watchdog", n, WDOG);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  task automatic acc(input bit wr, input int a, input int d);
    @(posedge clk); #1;
    c_valid = 1'b1; c_write = wr; c_addr = 18'(a); c_wdata = 8'(d);
    forever begin
      @(posedge clk); #1;
      if (req_ack) break;
    end
    c_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; c_valid = 1'b0; c_write = 1'b0; c_addr = '0; c_wdata = '0;
    repeat (3) @(negedge clk);
    chk({ras_n, cas_n, we_n, oe_n, dq_oe, req_ack, rsp_valid} == 7'b1111000,
        "R1 reset state", {ras_n, cas_n, we_n, oe_n, dq_oe, req_ack, rsp_valid}, 7'b1111000);
    @(posedge clk); #1 rst_n = 1'b1;

    // page hits: one row, several columns, write then read
    for (int i = 0; i < 8; i++) acc(1, (5 << 9) | i, i * 17 + 3);
    for (int i = 0; i < 8; i++) acc(0, (5 << 9) | i, 0);
    // row misses, alternating rows
    for (int i = 0; i < 10; i++) acc(1, (((i % 2) ? 200 : 100) << 9) | (i * 37 % 512), 8'hA0 + i);
    for (int i = 0; i < 10; i++) acc(0, (((i % 2) ? 200 : 100) << 9) | (i * 37 % 512), 0);
    // never-written words, top and bottom of the space
    acc(0, 18'h3FFFF, 0);
    acc(0, 0, 0);
    acc(0, (511 << 9) | 1, 0);
    // long same-row read stream across several refresh slots
    for (int i = 0; i < 700; i++) acc(0, (9 << 9) | (i % 512), 0);
    // idle with the page left open
    repeat (3500) @(posedge clk);
    // data survives refresh
    acc(0, (5 << 9) | 3, 0);
    acc(0, (200 << 9) | (9 * 37 % 512), 0);
    repeat (20) @(posedge clk);
    @(negedge clk); #1;
    chk(q_data.size() == 0, "R7 all reads answered", q_data.size(), 0);
    chk(refreshes >= n / REF_INT - 1, "R9 refresh count", refreshes, n / REF_INT - 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule